// File: doc/BRIEF.md
# Divisor-Counting Prime Tester

This block decides whether an unsigned 8-bit operand is prime. It does this by trying every candidate divisor from 1 up to the operand itself and counting how many of them leave no remainder. The operand is prime when exactly two candidates divide it. The work is split between a control state machine and a small datapath. The datapath holds the operand register, a candidate-index register with an end-of-range flag, a modulo unit that subtracts once per clock, a zero detector on the remainder and a saturating divisor tally.

A caller pulses `start_i` with the operand on `operand_i` while the unit is idle. The unit raises `busy_o` and works through the candidates. When the last candidate has been tested it drops `busy_o`, pulses `done_o` for one cycle and presents the verdict on `is_prime_o`. The verdict holds until the next job completes. The run time depends on the operand: each candidate costs a few control cycles plus one cycle per subtraction.

Top module: `prime_tester`

## Requirements
- R1: A `start_i` pulse sampled while `busy_o` is low captures `operand_i`, and `busy_o` is high from the following cycle.
- R2: For operands 2 to 255, `is_prime_o` reads 1 after `done_o` exactly when the operand has two divisors in 1..x (it is prime). Otherwise it reads 0.
- R3: Operand 0 skips the divisor loop. It completes with `is_prime_o` = 0 and `busy_o` high for a single cycle.
- R4: Operand 1 runs the loop once, finds one divisor and completes with `is_prime_o` = 0.
- R5: `done_o` is a one-cycle pulse, asserted in the first cycle in which `busy_o` is low again after a job.
- R6: `is_prime_o` changes only in the cycle in which `done_o` is high, so it holds from one completion until the next.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The running job finishes with the verdict for its own operand, and no second job follows.
- R8: Asserting `rst_n` low clears `busy_o`, `done_o` and `is_prime_o` at once, including in the middle of a job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, accepted only while idle |
| operand_i | input | 8 | Value to test, sampled with an accepted start |
| busy_o | output | 1 | High while a job is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| is_prime_o | output | 1 | Verdict: 1 = prime, 0 = not prime |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of a job while an earlier verdict of 1 is still held. Only that case shows that reset really clears the result, rather than leaving an old verdict behind. The stimulus first completes a prime operand so that `is_prime_o` is 1. It then starts a long composite job, pulls `rst_n` low partway through the loop and checks the outputs before and after release. A start pulse is also injected a few cycles into a job, and the bench confirms that exactly one completion follows with the first operand's verdict.

// File: rtl/prime_pkg.sv
package prime_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DECIDE = 2'd3
  } ctl_state_e;

  localparam int unsigned PRIME_DIVS = 2;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/loop_index.sv
module loop_index #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] idx_o,
  output logic         last_o
);

  logic [W-1:0] idx_q, idx_d;
  logic         idx_en;

  always_comb begin
    idx_en = load_i | step_i;
    idx_d  = idx_q;
    if (load_i)      idx_d = W'(1);
    else if (step_i) idx_d = idx_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == limit_i);

endmodule

// File: rtl/mod_sub.sv
module mod_sub #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] rem_o,
  output logic         fin_o
);

  logic [W-1:0] rem_q, rem_d;
  logic [W-1:0] div_q, div_d;
  logic         run_q, run_d;
  logic         fin_q, fin_d;
  logic         fits;

  assign fits = (rem_q >= div_q);

  always_comb begin
    rem_d = rem_q;
    div_d = div_q;
    run_d = run_q;
    fin_d = 1'b0;
    if (go_i) begin
      rem_d = dividend_i;
      div_d = divisor_i;
      run_d = 1'b1;
    end else if (run_q) begin
      if (fits) begin
        rem_d = rem_q - div_q;
      end else begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      div_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      div_q <= div_d;
      run_q <= run_d;
      fin_q <= fin_d;
    end
  end

  assign rem_o = rem_q;
  assign fin_o = fin_q;

endmodule

// File: rtl/ctrl_fsm.sv
module ctrl_fsm
  import prime_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic zero_op_i,
  input  logic fin_i,
  input  logic rem_zero_i,
  input  logic last_i,
  output logic capture_o,
  output logic go_o,
  output logic tally_o,
  output logic step_o,
  output logic decide_o,
  output logic busy_o
);

  ctl_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    capture_o = 1'b0;
    go_o      = 1'b0;
    tally_o   = 1'b0;
    step_o    = 1'b0;
    decide_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          capture_o = 1'b1;
          state_d   = zero_op_i ? ST_DECIDE : ST_LAUNCH;
        end
      end
      ST_LAUNCH: begin
        go_o    = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (fin_i) begin
          tally_o = rem_zero_i;
          if (last_i) begin
            state_d = ST_DECIDE;
          end else begin
            step_o  = 1'b1;
            state_d = ST_LAUNCH;
          end
        end
      end
      ST_DECIDE: begin
        decide_o = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/prime_tester.sv
module prime_tester
  import prime_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] operand_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         is_prime_o
);

  localparam int unsigned CNT_W   = $clog2(PRIME_DIVS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(PRIME_DIVS);

  logic         rst_n_s;
  logic         capture, go, tally, step, decide;
  logic         fin, last, rem_zero;
  logic [W-1:0] x_q;
  logic [W-1:0] idx;
  logic [W-1:0] rem;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic         cnt_en;
  logic         done_q, res_q;

  rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     x_q <= '0;
    else if (capture) x_q <= operand_i;
  end

  ctrl_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (start_i),
    .zero_op_i  (operand_i == '0),
    .fin_i      (fin),
    .rem_zero_i (rem_zero),
    .last_i     (last),
    .capture_o  (capture),
    .go_o       (go),
    .tally_o    (tally),
    .step_o     (step),
    .decide_o   (decide),
    .busy_o     (busy_o)
  );

  loop_index #(.W(W)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load_i  (capture),
    .step_i  (step),
    .limit_i (x_q),
    .idx_o   (idx),
    .last_o  (last)
  );

  mod_sub #(.W(W)) u_mod (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .go_i       (go),
    .dividend_i (x_q),
    .divisor_i  (idx),
    .rem_o      (rem),
    .fin_o      (fin)
  );

  assign rem_zero = (rem == '0);

  always_comb begin
    cnt_en = capture | (tally & (cnt_q != CNT_MAX));
    cnt_d  = capture ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      done_q <= 1'b0;
      res_q  <= 1'b0;
    end else begin
      done_q <= decide;
      if (decide) res_q <= (cnt_q == CNT_HIT);
    end
  end

  assign done_o     = done_q;
  assign is_prime_o = res_q;

endmodule

// File: rtl/prime_tester_chk.sv
module prime_tester_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         is_prime_o,
  input logic [W-1:0] x_q
);

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  p_zero_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && x_q == '0) |-> !is_prime_o);

  p_one_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && x_q == W'(1)) |-> !is_prime_o);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(is_prime_o));

  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(x_q));

endmodule

bind prime_tester prime_tester_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .is_prime_o (is_prime_o),
  .x_q        (x_q)
);

// File: tb/prime_tester_test.sv
`timescale 1ns/1ps
module prime_tester_test;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [7:0] operand_i;
  logic       busy_o, done_o, is_prime_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit finished = 0;

  prime_tester #(.W(8)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .operand_i  (operand_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .is_prime_o (is_prime_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 190000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic bit ref_prime(int x);
    int n = 0;
    for (int i = 1; i <= x; i++) if (x % i == 0) n++;
    return (n == 2);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(string req, output int ncyc);
    ncyc = 0;
    while (!done_o && ncyc < 6000) begin
      @(negedge clk);
      ncyc++;
    end
    check({req, " completion seen"}, done_o, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; operand_i = '0;
    repeat (3) @(negedge clk);
    check("R8 busy in reset", busy_o, 0);
    check("R8 done in reset", done_o, 0);
    check("R8 result in reset", is_prime_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_run(int x, string req, bit full);
    int n;
    bit exp = ref_prime(x);
    start_i = 1'b1; operand_i = 8'(x);
    @(negedge clk);
    start_i = 1'b0; operand_i = 8'hA5;
    if (full) check("R1 busy after start", busy_o, 1);
    wait_done(req, n);
    check({req, " verdict"}, is_prime_o, exp);
    if (full) begin
      check("R5 busy low with done", busy_o, 0);
      @(negedge clk);
      check("R5 done one cycle", done_o, 0);
      check("R6 verdict held", is_prime_o, exp);
    end else begin
      @(negedge clk);
    end
  endtask

  task automatic t_zero();
    start_i = 1'b1; operand_i = 8'd0;
    @(negedge clk);
    start_i = 1'b0;
    check("R3 busy after zero start", busy_o, 1);
    @(negedge clk);
    check("R3 done after one busy cycle", done_o, 1);
    check("R3 zero verdict", is_prime_o, 0);
    @(negedge clk);
  endtask

  task automatic t_start_while_busy();
    int n;
    start_i = 1'b1; operand_i = 8'd9;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    start_i = 1'b1; operand_i = 8'd7;
    @(negedge clk);
    start_i = 1'b0;
    wait_done("R7", n);
    check("R7 verdict of first operand", is_prime_o, 0);
    repeat (3) @(negedge clk);
    check("R7 no second job", busy_o, 0);
  endtask

  task automatic t_mid_reset();
    t_run(13, "R8 setup", 1'b0);
    check("R8 prime held before reset", is_prime_o, 1);
    start_i = 1'b1; operand_i = 8'd200;
    @(negedge clk);
    start_i = 1'b0;
    repeat (40) @(negedge clk);
    check("R8 busy mid job", busy_o, 1);
    rst_n = 1'b0;
    #1;
    check("R8 busy cleared", busy_o, 0);
    check("R8 result cleared", is_prime_o, 0);
    check("R8 done cleared", done_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 still idle after release", busy_o, 0);
  endtask

  initial begin
    t_reset();
    t_zero();
    t_run(1, "R4", 1'b1);
    t_run(2, "R2", 1'b1);
    t_run(4, "R2", 1'b1);
    t_run(97, "R2", 1'b1);
    t_run(255, "R2", 1'b1);
    t_run(251, "R2", 1'b1);
    for (int x = 2; x <= 90; x++) t_run(x, "R2 sweep", 1'b0);
    t_start_while_busy();
    t_mid_reset();
    t_run(211, "R2 after reset", 1'b1);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule